// File: doc/BRIEF.md
# SMI and Debug Trap Sequencer

This block decides the order of service when one instruction raises both a system-management interrupt from an I/O trap and a debug breakpoint trap. It watches single-cycle event inputs from the execution core and issues three kinds of request: enter system-management mode, write the debug fault frame, or discard a debug trap that was held back. It also pulses save and restore strobes for the debug registers that are preserved in hardware across system-management mode. There is one strobe bit per register, and the number of registers is a parameter.

When the SMI and the debug trap arrive in the same cycle and the trapped-I/O qualifier is high, the SMI wins. The debug trap is recorded in a single pending flag and carried through system-management mode. When the RSM cycle is seen, the save-area I/O restart flag is sampled. If the flag is clear, the deferred trap is delivered as a one-cycle pulse once normal execution resumes. If it is set, the trap is dropped, because re-executing the I/O instruction will raise it again. A debug trap that is not covered by this deferral passes to the output in the same cycle. The SMM microcode, the frame format and breakpoint matching are handled by other blocks.

Top module: `smi_dbg_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the sequencer to idle and clears the pending flag. In the cycle after reset, with all event inputs low, every output is low, and a following `rsm_i` produces no restore strobe.
- R2: An `smi_req_i` sampled while idle raises `smm_enter_o` from the next cycle. With `HOLD_ENTER`=1 (the default), `smm_enter_o` stays high until the cycle in which `smm_entered_i` is sampled, and is low in the cycle after that.
- R3: A `dbg_trap_i` that is not being deferred appears on `dbg_deliver_o` in the same cycle. This covers a trap with no SMI, and a trap whose SMI comes without `io_trap_ok_i`.
- R4: When `smi_req_i`, `dbg_trap_i` and `io_trap_ok_i` are all high in an idle cycle, `dbg_deliver_o` stays low in that cycle and the trap becomes pending. The SMI is still serviced.
- R5: `smm_entered_i` while entry is outstanding drives every bit of `dr_save_o` high in that same cycle, for exactly one cycle.
- R6: `rsm_i` while in system-management mode drives every bit of `dr_restore_o` high in that same cycle. `io_restart_i` is sampled in that cycle.
- R7: If a trap is pending and the sampled restart flag is 0, `dbg_deliver_o` pulses for one cycle, two cycles after the RSM cycle.
- R8: If a trap is pending and the sampled restart flag is 1, `dbg_drop_o` pulses for one cycle, one cycle after the RSM cycle. The deferred trap is then never delivered.
- R9: If no trap is pending, neither `dbg_drop_o` nor a deferred `dbg_deliver_o` follows RSM, whatever the value of the restart flag.
- R10: `smi_req_i` is ignored unless the sequencer is idle, and `rsm_i` is ignored unless it is in system-management mode.
- R11: A `dbg_trap_i` raised while in system-management mode passes straight to `dbg_deliver_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req_i | input | 1 | SMI request pulse |
| dbg_trap_i | input | 1 | Debug breakpoint trap detected |
| io_trap_ok_i | input | 1 | SMI came from a trapped I/O instruction inside the trap window |
| smm_entered_i | input | 1 | SMM entry completed |
| rsm_i | input | 1 | RSM executed |
| io_restart_i | input | 1 | Save-area I/O restart flag, valid with `rsm_i` |
| smm_enter_o | output | 1 | Request to enter SMM |
| dbg_deliver_o | output | 1 | Deliver debug fault frame |
| dbg_drop_o | output | 1 | Discard the pending debug trap |
| dr_save_o | output | N_AUTO_DR | Save strobes for the hardware-preserved debug registers |
| dr_restore_o | output | N_AUTO_DR | Restore strobes for the hardware-preserved debug registers |

## Verification
The timing of each result is as follows:
- The pass-through trap, the save strobes and the restore strobes are combinational. They are due in the same cycle as their stimulus.
- `smm_enter_o` is due one cycle after the request.
- The drop pulse is due one cycle after RSM, and the deferred delivery two cycles after RSM.

The bench drives each stimulus just after a falling edge and samples one time step later, before the next rising edge. The same-cycle results are therefore read in the cycle of their stimulus, and every later result is counted in whole clock steps from the RSM or request cycle. Each step through a scenario also checks that no pulse appears early or lasts into the following cycle.

// File: rtl/smi_dbg_pkg.sv
package smi_dbg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ENTRY = 3'd1,
      ST_SMM   = 3'd2,
      ST_RCHK  = 3'd3,
      ST_DELIV = 3'd4
   } seq_state_e;

   localparam int unsigned STATE_W = 3;

   function automatic logic is_idle(input seq_state_e s);
      return s == ST_IDLE;
   endfunction

endpackage

// File: rtl/smi_dbg_classify.sv
module smi_dbg_classify
   import smi_dbg_pkg::*;
(
   input  seq_state_e state_i,
   input  logic       smi_req_i,
   input  logic       dbg_trap_i,
   input  logic       io_trap_ok_i,
   output logic       accept_smi_o,
   output logic       defer_dbg_o,
   output logic       pass_dbg_o
);

   logic idle;

   always_comb begin
      idle         = is_idle(state_i);
      accept_smi_o = idle & smi_req_i;
      defer_dbg_o  = idle & smi_req_i & dbg_trap_i & io_trap_ok_i;
      pass_dbg_o   = dbg_trap_i & ~defer_dbg_o;
   end

endmodule

// File: rtl/smi_dbg_fsm.sv
module smi_dbg_fsm
   import smi_dbg_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       accept_smi_i,
   input  logic       defer_dbg_i,
   input  logic       smm_entered_i,
   input  logic       rsm_i,
   input  logic       io_restart_i,
   output seq_state_e state_o,
   output logic       save_ev_o,
   output logic       restore_ev_o,
   output logic       drop_ev_o,
   output logic       late_deliver_o
);

   seq_state_e state_q, state_d;
   logic       pending_q, pending_d;
   logic       restart_q, restart_d;

   always_comb begin
      state_d        = state_q;
      pending_d      = pending_q;
      restart_d      = restart_q;
      save_ev_o      = 1'b0;
      restore_ev_o   = 1'b0;
      drop_ev_o      = 1'b0;
      late_deliver_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept_smi_i) begin
               state_d   = ST_ENTRY;
               pending_d = defer_dbg_i;
            end
         end
         ST_ENTRY: begin
            if (smm_entered_i) begin
               save_ev_o = 1'b1;
               state_d   = ST_SMM;
            end
         end
         ST_SMM: begin
            if (rsm_i) begin
               restore_ev_o = 1'b1;
               restart_d    = io_restart_i;
               state_d      = ST_RCHK;
            end
         end
         ST_RCHK: begin
            pending_d = 1'b0;
            if (pending_q && restart_q) begin
               drop_ev_o = 1'b1;
               state_d   = ST_IDLE;
            end else if (pending_q) begin
               state_d = ST_DELIV;
            end else begin
               state_d = ST_IDLE;
            end
         end
         ST_DELIV: begin
            late_deliver_o = 1'b1;
            state_d        = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         pending_q <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         pending_q <= pending_d;
         restart_q <= restart_d;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/smi_dbg_enter.sv
module smi_dbg_enter
   import smi_dbg_pkg::*;
#(
   parameter bit HOLD_ENTER = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  seq_state_e state_i,
   output logic       smm_enter_o
);

   logic in_entry;
   assign in_entry = (state_i == ST_ENTRY);

   generate
      if (HOLD_ENTER) begin : g_level
         assign smm_enter_o = in_entry;
      end else begin : g_pulse
         logic was_entry_q;
         always_ff @(posedge clk) begin
            if (rst) was_entry_q <= 1'b0;
            else     was_entry_q <= in_entry;
         end
         assign smm_enter_o = in_entry & ~was_entry_q;
      end
   endgenerate

endmodule

// File: rtl/smi_dbg_dr_strobe.sv
module smi_dbg_dr_strobe #(
   parameter int unsigned N_AUTO_DR = 2
) (
   input  logic                 save_ev_i,
   input  logic                 restore_ev_i,
   output logic [N_AUTO_DR-1:0] dr_save_o,
   output logic [N_AUTO_DR-1:0] dr_restore_o
);

   generate
      for (genvar i = 0; i < N_AUTO_DR; i++) begin : g_reg
         assign dr_save_o[i]    = save_ev_i;
         assign dr_restore_o[i] = restore_ev_i;
      end
   endgenerate

endmodule

// File: rtl/smi_dbg_seq.sv
module smi_dbg_seq
   import smi_dbg_pkg::*;
#(
   parameter int unsigned N_AUTO_DR  = 2,
   parameter bit          HOLD_ENTER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smi_req_i,
   input  logic                 dbg_trap_i,
   input  logic                 io_trap_ok_i,
   input  logic                 smm_entered_i,
   input  logic                 rsm_i,
   input  logic                 io_restart_i,
   output logic                 smm_enter_o,
   output logic                 dbg_deliver_o,
   output logic                 dbg_drop_o,
   output logic [N_AUTO_DR-1:0] dr_save_o,
   output logic [N_AUTO_DR-1:0] dr_restore_o
);

   generate
      if (N_AUTO_DR < 1 || N_AUTO_DR > 16) begin : g_bad_n
         $error("smi_dbg_seq: N_AUTO_DR must be 1..16");
      end
   endgenerate

   seq_state_e state;
   logic accept_smi, defer_dbg, pass_dbg;
   logic save_ev, restore_ev, drop_ev, late_deliver;

   smi_dbg_classify u_cls (
      .state_i      (state),
      .smi_req_i    (smi_req_i),
      .dbg_trap_i   (dbg_trap_i),
      .io_trap_ok_i (io_trap_ok_i),
      .accept_smi_o (accept_smi),
      .defer_dbg_o  (defer_dbg),
      .pass_dbg_o   (pass_dbg)
   );

   smi_dbg_fsm u_fsm (
      .clk            (clk),
      .rst            (rst),
      .accept_smi_i   (accept_smi),
      .defer_dbg_i    (defer_dbg),
      .smm_entered_i  (smm_entered_i),
      .rsm_i          (rsm_i),
      .io_restart_i   (io_restart_i),
      .state_o        (state),
      .save_ev_o      (save_ev),
      .restore_ev_o   (restore_ev),
      .drop_ev_o      (drop_ev),
      .late_deliver_o (late_deliver)
   );

   smi_dbg_enter #(.HOLD_ENTER(HOLD_ENTER)) u_ent (
      .clk         (clk),
      .rst         (rst),
      .state_i     (state),
      .smm_enter_o (smm_enter_o)
   );

   smi_dbg_dr_strobe #(.N_AUTO_DR(N_AUTO_DR)) u_dr (
      .save_ev_i    (save_ev),
      .restore_ev_i (restore_ev),
      .dr_save_o    (dr_save_o),
      .dr_restore_o (dr_restore_o)
   );

   assign dbg_deliver_o = pass_dbg | late_deliver;
   assign dbg_drop_o    = drop_ev;

endmodule

// File: rtl/smi_dbg_chk.sv
module smi_dbg_chk #(
   parameter int unsigned N_AUTO_DR = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 smi_req_i,
   input logic                 dbg_trap_i,
   input logic                 smm_entered_i,
   input logic                 rsm_i,
   input logic                 io_restart_i,
   input logic                 smm_enter_o,
   input logic                 dbg_deliver_o,
   input logic                 dbg_drop_o,
   input logic [N_AUTO_DR-1:0] dr_save_o,
   input logic [N_AUTO_DR-1:0] dr_restore_o
);

   assert_enter_after_req_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(smm_enter_o) |-> $past(smi_req_i));

   assert_save_needs_entered_R5: assert property (@(posedge clk) disable iff (rst)
      (|dr_save_o) |-> smm_entered_i);

   assert_save_single_R5: assert property (@(posedge clk) disable iff (rst)
      (|dr_save_o) |=> !(|dr_save_o));

   assert_restore_needs_rsm_R6: assert property (@(posedge clk) disable iff (rst)
      (|dr_restore_o) |-> rsm_i);

   assert_save_restore_apart_R10: assert property (@(posedge clk) disable iff (rst)
      !((|dr_save_o) && (|dr_restore_o)));

   assert_drop_after_restart_R8: assert property (@(posedge clk) disable iff (rst)
      dbg_drop_o |-> ($past(|dr_restore_o) && $past(io_restart_i)));

   assert_drop_single_R8: assert property (@(posedge clk) disable iff (rst)
      dbg_drop_o |=> !dbg_drop_o);

   assert_late_deliver_R7: assert property (@(posedge clk) disable iff (rst)
      (dbg_deliver_o && !dbg_trap_i) |-> ($past(|dr_restore_o, 2) && !$past(io_restart_i, 2)));

endmodule

bind smi_dbg_seq smi_dbg_chk #(.N_AUTO_DR(N_AUTO_DR)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .smi_req_i     (smi_req_i),
   .dbg_trap_i    (dbg_trap_i),
   .smm_entered_i (smm_entered_i),
   .rsm_i         (rsm_i),
   .io_restart_i  (io_restart_i),
   .smm_enter_o   (smm_enter_o),
   .dbg_deliver_o (dbg_deliver_o),
   .dbg_drop_o    (dbg_drop_o),
   .dr_save_o     (dr_save_o),
   .dr_restore_o  (dr_restore_o)
);

// File: tb/sim_smi_dbg_seq.sv
module sim_smi_dbg_seq;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smi_req_i = 0, dbg_trap_i = 0, io_trap_ok_i = 0;
   logic smm_entered_i = 0, rsm_i = 0, io_restart_i = 0;
   logic smm_enter_o, dbg_deliver_o, dbg_drop_o;
   logic [1:0] dr_save_o, dr_restore_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   smi_dbg_seq #(.N_AUTO_DR(2), .HOLD_ENTER(1'b1)) u0 (
      .clk(clk), .rst(rst), .smi_req_i(smi_req_i), .dbg_trap_i(dbg_trap_i),
      .io_trap_ok_i(io_trap_ok_i), .smm_entered_i(smm_entered_i), .rsm_i(rsm_i),
      .io_restart_i(io_restart_i), .smm_enter_o(smm_enter_o),
      .dbg_deliver_o(dbg_deliver_o), .dbg_drop_o(dbg_drop_o),
      .dr_save_o(dr_save_o), .dr_restore_o(dr_restore_o)
   );

   // vector: {smi, dbg, io_ok, restart, exp_pass, exp_late, exp_drop}
   localparam int NV = 7;
   localparam logic [6:0] VEC [NV] = '{
      7'b1110_010,  // R7 deferred, restart clear
      7'b1111_001,  // R8 deferred, restart set
      7'b1100_100,  // R3 SMI without qualifier: no deferral
      7'b0110_100,  // R3 lone trap
      7'b1011_000,  // R9 SMI, no trap, restart set
      7'b1010_000,  // R9 SMI, no trap, restart clear
      7'b0000_000   // idle
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic run_vec(input logic [6:0] v);
      smi_req_i = v[6]; dbg_trap_i = v[5]; io_trap_ok_i = v[4];
      #1;
      chk(v[6] & v[5] & v[4] ? "R4" : "R3", dbg_deliver_o, v[2]);
      chk("R2", smm_enter_o, 0);
      tick();
      smi_req_i = 0; dbg_trap_i = 0; io_trap_ok_i = 0;
      #1;
      chk("R2", smm_enter_o, v[6]);
      chk("R4", dbg_deliver_o, 0);
      if (v[6]) begin
         smm_entered_i = 1; #1;
         chk("R5", dr_save_o, 2'b11);
         tick();
         smm_entered_i = 0; #1;
         chk("R2", smm_enter_o, 0);
         chk("R5", dr_save_o, 2'b00);
         rsm_i = 1; io_restart_i = v[3]; #1;
         chk("R6", dr_restore_o, 2'b11);
         tick();
         rsm_i = 0; io_restart_i = 0; #1;
         chk("R8", dbg_drop_o, v[0]);
         chk("R7", dbg_deliver_o, 0);
         tick(); #1;
         chk("R7", dbg_deliver_o, v[1]);
         chk("R8", dbg_drop_o, 0);
         tick(); #1;
         chk("R9", dbg_deliver_o, 0);
      end
      tick();
   endtask

   initial begin
      #2000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst = 0; #1;
      // R1 reset state
      chk("R1", {smm_enter_o, dbg_deliver_o, dbg_drop_o, dr_save_o, dr_restore_o}, 0);
      tick();

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R2 hold until entered; R10 SMI ignored outside idle; R11 pass-through in SMM
      smi_req_i = 1; tick(); smi_req_i = 0;
      tick(); tick(); #1;
      chk("R2", smm_enter_o, 1);
      smi_req_i = 1; smm_entered_i = 1; tick();
      smi_req_i = 0; smm_entered_i = 0;
      dbg_trap_i = 1; #1;
      chk("R11", dbg_deliver_o, 1);
      tick(); dbg_trap_i = 0;
      smi_req_i = 1; io_trap_ok_i = 1; dbg_trap_i = 1; #1;
      chk("R10", dbg_deliver_o, 1);
      tick(); smi_req_i = 0; io_trap_ok_i = 0; dbg_trap_i = 0; #1;
      chk("R10", smm_enter_o, 0);
      rsm_i = 1; tick(); rsm_i = 0;
      tick(); tick(); #1;
      chk("R10", smm_enter_o, 0);
      // R10 rsm ignored while idle
      rsm_i = 1; #1;
      chk("R10", dr_restore_o, 2'b00);
      tick(); rsm_i = 0; #1;
      chk("R10", dbg_drop_o, 0);

      // R1 reset in the middle of a deferred flow
      smi_req_i = 1; dbg_trap_i = 1; io_trap_ok_i = 1; tick();
      smi_req_i = 0; dbg_trap_i = 0; io_trap_ok_i = 0;
      smm_entered_i = 1; tick(); smm_entered_i = 0;
      rst = 1; tick(); rst = 0; #1;
      chk("R1", {smm_enter_o, dbg_deliver_o, dbg_drop_o}, 0);
      rsm_i = 1; #1;
      chk("R1", dr_restore_o, 2'b00);
      tick(); rsm_i = 0; #1;
      chk("R1", dbg_drop_o, 0);
      tick(); #1;
      chk("R1", dbg_deliver_o, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule